// File: doc/BRIEF.md
# Multiplier-Free Constant Row Filter

This block is the per-row engine of a separable-by-rows two-dimensional image filter. It takes a stream of unsigned 8-bit pixels, qualified by a valid strobe. For each accepted pixel it produces one row-partial sum: the convolution of the most recent accepted pixels with a fixed set of 17 coefficients. Several instances, one per kernel row, feed an external adder tree.

The filter has no multipliers. Each coefficient is written at elaboration time as up to four signed power-of-two digit slots. Every tap product is built by shifting the sample and adding or subtracting the shifted copies. One two-digit pattern, `x + (x << SHARE_SHIFT)`, is formed once per sample, and any digit slot of any tap may use it in place of a plain shifted sample. When the coefficient set is mirror-symmetric, each product is built once and used by both mirrored taps.

The structure is transposed form: every tap product is made from the current sample, and a chain of partial-sum registers carries history. That chain advances only on accepted samples. The output register adds one cycle of latency.

Top module: `csdrf_row_filter`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, out_valid is 0 and out_data is 0. All sample history is cleared, so the first outputs after reset see zero for every earlier sample.
- R2: out_valid is high in exactly the cycle after each cycle in which in_valid was high, and low otherwise.
- R3: For the n-th accepted sample x[n], out_data equals sum over k=0..16 of c[k]*x[n-k], where c[k] is tap k's decoded coefficient (k=0 weights the newest sample). The default set is c = -2, 3, 10, -20, 27, 65, 150, 300, 400, 300, 150, 65, 27, -20, 10, 3, -2.
- R4: A cycle with in_valid low does not change the history or out_data, whatever in_data carries then.
- R5: in_data is treated as unsigned and zero-extended, so 255 weighs as +255.
- R6: Each digit slot is one byte: bits 7:6 hold the sign (01 add, 11 subtract, 00 empty slot adding nothing), bit 5 selects the shared pattern instead of the plain sample, and bits 4:0 give the left shift. Tap k's slot j sits at bits (k*NDIG+j)*8 of COEF_DIGITS.
- R7: The shared pattern is x + (x << SHARE_SHIFT) with SHARE_SHIFT=2 by default (5x). It is computed once per sample and used by every slot that selects it.
- R8: out_data is signed, COEF_W+IN_W+clog2(NTAPS)+1 = 30 bits wide, and it never wraps, even for a long run of 255-valued pixels.
- R9: With SYMMETRIC=1, tap k and tap NTAPS-1-k share a single product network, and the output equals the full 17-tap sum of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe; history advances only when high |
| in_data | input | 8 | Unsigned pixel sample |
| out_valid | output | 1 | Output strobe, one cycle after in_valid |
| out_data | output | 30 | Signed row-partial sum |

## Verification
The impulse tests send a single 1 and then a single 255, with idle gaps between samples. They catch four kinds of error: a digit slot decoded with the wrong sign or shift, a shared-pattern slot using the plain sample, a mirrored tap bound to the wrong product, and a sign-extended pixel that would make 255 weigh as -1. Junk on in_data while in_valid is low exposes a chain that advances on idle cycles or an output register that reloads. A long run of 255s drives the sum to its largest magnitude and would show truncation of the internal width. A reset in mid-stream, followed by an impulse, shows whether stale partial sums leak into fresh results.

// File: rtl/csdrf_pkg.sv
package csdrf_pkg;
   localparam int MAX_DIG = 4;
   localparam int DIG_W   = 8;

   // Value of one digit slot, in units of the input sample.
   function automatic int digit_value(input logic [DIG_W-1:0] d, input int share_shift);
      int mag;
      mag = d[5] ? (1 + (1 << share_shift)) : 1;
      mag = mag << d[4:0];
      case (d[7:6])
         2'b01:   return mag;
         2'b11:   return -mag;
         default: return 0;
      endcase
   endfunction

   function automatic int coef_value(input logic [MAX_DIG*DIG_W-1:0] w, input int share_shift);
      int acc;
      acc = 0;
      for (int j = 0; j < MAX_DIG; j++) acc += digit_value(w[j*DIG_W +: DIG_W], share_shift);
      return acc;
   endfunction

   function automatic bit slot_legal(input logic [MAX_DIG*DIG_W-1:0] w);
      bit ok;
      ok = 1'b1;
      for (int j = 0; j < MAX_DIG; j++) if (w[j*DIG_W+6 +: 2] == 2'b10) ok = 1'b0;
      return ok;
   endfunction
endpackage

// File: rtl/csdrf_tap_product.sv
module csdrf_tap_product #(
   parameter int NDIG        = 4,
   parameter int ACC_W       = 30,
   parameter logic [NDIG*8-1:0] DIGITS = '0
) (
   input  logic signed [ACC_W-1:0] x,
   input  logic signed [ACC_W-1:0] pat,
   output logic signed [ACC_W-1:0] prod
);
   logic signed [ACC_W-1:0] term [NDIG];

   for (genvar j = 0; j < NDIG; j++) begin : g_dig
      localparam logic [1:0] SG   = DIGITS[j*8+6 +: 2];
      localparam bit         KIND = DIGITS[j*8+5];
      localparam int         SH   = int'(DIGITS[j*8 +: 5]);
      if (SG == 2'b01) begin : g_add
         if (KIND) begin : g_p
            assign term[j] = pat <<< SH;
         end else begin : g_x
            assign term[j] = x <<< SH;
         end
      end else if (SG == 2'b11) begin : g_sub
         if (KIND) begin : g_p
            assign term[j] = -(pat <<< SH);
         end else begin : g_x
            assign term[j] = -(x <<< SH);
         end
      end else begin : g_none
         assign term[j] = '0;
      end
   end

   always_comb begin
      prod = '0;
      for (int j = 0; j < NDIG; j++) prod = prod + term[j];
   end
endmodule

// File: rtl/csdrf_tchain.sv
module csdrf_tchain #(
   parameter int NTAPS = 17,
   parameter int ACC_W = 30
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         en,
   input  logic [NTAPS-1:0][ACC_W-1:0]  prod,
   output logic signed [ACC_W-1:0]      y
);
   logic [NTAPS-2:0][ACC_W-1:0] z;

   for (genvar k = 0; k < NTAPS-1; k++) begin : g_stage
      logic signed [ACC_W-1:0] nxt;
      if (k == NTAPS-2) begin : g_last
         assign nxt = $signed(prod[k+1]);
      end else begin : g_mid
         assign nxt = $signed(prod[k+1]) + $signed(z[k+1]);
      end
      always_ff @(posedge clk) begin
         if (!rst_n)  z[k] <= '0;
         else if (en) z[k] <= nxt;
      end
   end

   assign y = $signed(prod[0]) + $signed(z[0]);

   AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(z)); // R4
endmodule

// File: rtl/csdrf_row_filter.sv
module csdrf_row_filter #(
   parameter int NTAPS       = 17,
   parameter int NDIG        = 4,
   parameter int IN_W        = 8,
   parameter int COEF_W      = 16,
   parameter int SHARE_SHIFT = 2,
   parameter bit SYMMETRIC   = 1'b1,
   parameter logic [NTAPS*NDIG*8-1:0] COEF_DIGITS = {
      32'h000000C1, 32'h0000C042, 32'h00000061, 32'h000000E2, 32'h00C0C245,
      32'h00004046, 32'h0000E165, 32'h0000E266, 32'h00006466, 32'h0000E266,
      32'h0000E165, 32'h00004046, 32'h00C0C245, 32'h000000E2, 32'h00000061,
      32'h0000C042, 32'h000000C1},
   localparam int ACC_W = COEF_W + IN_W + $clog2(NTAPS) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_data,
   output logic             out_valid,
   output logic [ACC_W-1:0] out_data
);
   import csdrf_pkg::*;

   localparam int TAP_W = NDIG * 8;
   localparam int CMAX  = (1 << (COEF_W-1)) - 1;

   initial begin : cfg_check
      AST_CFG_DIGITS: assert (NDIG >= 1 && NDIG <= MAX_DIG) else $error("NDIG out of range"); // R6
      AST_CFG_TAPS:   assert (NTAPS >= 2) else $error("NTAPS too small"); // R3
      AST_CFG_WIDTH:  assert (IN_W >= 1 && ACC_W <= 32) else $error("width out of range"); // R8
   end

   logic signed [ACC_W-1:0]     x_ext;
   logic signed [ACC_W-1:0]     pat;
   logic [NTAPS-1:0][ACC_W-1:0] prod;
   logic signed [ACC_W-1:0]     y;

   assign x_ext = $signed({{(ACC_W-IN_W){1'b0}}, in_data});
   assign pat   = x_ext + (x_ext <<< SHARE_SHIFT);

   for (genvar k = 0; k < NTAPS; k++) begin : g_tap
      localparam int MIR = NTAPS - 1 - k;
      localparam logic [TAP_W-1:0] TD = COEF_DIGITS[k*TAP_W +: TAP_W];
      localparam logic [TAP_W-1:0] MD = COEF_DIGITS[MIR*TAP_W +: TAP_W];
      localparam int CV = coef_value({{(MAX_DIG*8-TAP_W){1'b0}}, TD}, SHARE_SHIFT);

      initial begin : tap_check
         AST_CFG_SLOT:  assert (slot_legal({{(MAX_DIG*8-TAP_W){1'b0}}, TD})) else $error("bad sign code"); // R6
         AST_CFG_RANGE: assert (CV <= CMAX && CV >= -CMAX-1) else $error("coefficient exceeds word"); // R8
         if (SYMMETRIC) begin
            AST_CFG_MIRROR: assert (TD == MD) else $error("coefficients not mirrored"); // R9
         end
      end

      if (!SYMMETRIC || k <= MIR) begin : g_own
         logic signed [ACC_W-1:0] p;
         csdrf_tap_product #(.NDIG(NDIG), .ACC_W(ACC_W), .DIGITS(TD)) u_prod (
            .x(x_ext), .pat(pat), .prod(p));
         assign prod[k] = p;
      end else begin : g_shared
         assign prod[k] = prod[MIR];
      end

      AST_TAP_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |-> $signed(prod[k]) == x_ext * CV); // R7
   end

   csdrf_tchain #(.NTAPS(NTAPS), .ACC_W(ACC_W)) u_chain (
      .clk(clk), .rst_n(rst_n), .en(in_valid), .prod(prod), .y(y));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= y;
      end
   end

   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R2
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R2
   AST_OUT_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data)); // R4
endmodule

// File: tb/sim_csdrf_row_filter.sv
`timescale 1ns/1ps
module sim_csdrf_row_filter;
   localparam int NT = 17;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        out_valid;
   logic [29:0] out_data;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   int coef [NT] = '{-2, 3, 10, -20, 27, 65, 150, 300, 400, 300, 150, 65, 27, -20, 10, 3, -2};
   int hist [NT];
   int last_exp = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;

   csdrf_row_filter u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_hist();
      for (int k = 0; k < NT; k++) hist[k] = 0;
      last_exp = 0;
   endtask

   task automatic cyc(input bit v, input int x, input string req);
      int e;
      @(negedge clk);
      in_valid = v;
      in_data  = x[7:0];
      if (v) begin
         for (int k = NT-1; k > 0; k--) hist[k] = hist[k-1];
         hist[0] = x & 255;
         e = 0;
         for (int k = 0; k < NT; k++) e += coef[k] * hist[k];
         last_exp = e;
      end
      @(posedge clk);
      #2;
      check(out_valid == v, "R2", int'(out_valid), int'(v));
      check($signed(out_data) == last_exp, req, $signed(out_data), last_exp);
   endtask

   initial begin
      clear_hist();
      repeat (3) @(posedge clk);
      #2;
      check(out_valid == 1'b0, "R1", int'(out_valid), 0);
      check(out_data == '0, "R1", int'(out_data), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      check(out_valid == 1'b0 && out_data == '0, "R1", int'(out_data), 0);

      // R3 R6 R7 R9: unit impulse walks out every coefficient, idle gaps between
      cyc(1'b1, 1, "R3");
      for (int i = 0; i < NT + 2; i++) begin
         cyc(1'b0, 0, "R4");
         cyc(1'b1, 0, "R6");
      end

      // R4: junk on in_data while idle must be ignored
      for (int i = 0; i < 6; i++) cyc(1'b0, 200 + i, "R4");
      cyc(1'b1, 255, "R5");
      for (int i = 0; i < NT; i++) begin
         cyc(1'b0, 99, "R4");
         cyc(1'b1, 0, "R5");
      end

      // R3: ramp
      for (int i = 0; i < 40; i++) cyc(1'b1, i * 7, "R3");

      // R3 R4: pseudo-random samples with random idle cycles
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cyc(lfsr[3] | lfsr[9], int'(lfsr[15:8]), "R3");
      end

      // R8: longest all-maximum run
      for (int i = 0; i < 3 * NT; i++) cyc(1'b1, 255, "R8");

      // R1: reset mid-stream clears history
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b1;
      in_data = 8'd77;
      @(posedge clk);
      #2;
      check(out_valid == 1'b0 && out_data == '0, "R1", int'(out_data), 0);
      @(negedge clk);
      rst_n = 1'b1;
      in_valid = 1'b0;
      clear_hist();
      cyc(1'b1, 3, "R1");
      for (int i = 0; i < NT; i++) cyc(1'b1, 0, "R1");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule